// File: doc/BRIEF.md
# Multicycle 8-bit RISC processor core

This block is a compact processor that executes a small load/store instruction set with 32-bit instruction words on an 8-bit datapath. Every instruction word is pulled in over a byte-wide memory port, one byte per cycle, into an instruction register. A state machine then reuses one ALU and the single memory port across decode, execute, memory and write-back steps. Program counter, general registers and ALU are all one byte wide, and the register file holds eight entries. Entry 0 is the constant zero.

The core talks to a byte-addressed memory with a combinational read path and a clocked write. Code and data share the 256-byte space. Branch and jump targets are word-aligned: the offset or destination field is shifted left by two bits and the result is cut to eight bits.

Instruction fields: opcode in bits 31..26, first source (ra) in 25..21, second source or target (rb) in 20..16, R-type destination (rd) in 15..11, function code in 5..0, and a 16-bit immediate in 15..0. Only the low three bits of a register field are used. Opcodes: 0 register-register, 2 jump, 4 branch-if-equal, 8 add-immediate, 32 load byte, 40 store byte. Function codes: 32 add, 34 subtract, 36 AND, 37 OR, 42 signed set-less-than.

Top module: `mcpu8`

## Requirements
- R1: While reset is high and in the first cycle after it, the core issues a read at address 0 and no write. Reset clears the program counter and all registers to zero.
- R2: An instruction is fetched as four reads at consecutive addresses, one per cycle. The first byte goes to instruction bits 31..24 and the last byte to bits 7..0. A decode cycle with no strobe follows.
- R3: Register 0 always reads as zero, and a write aimed at it is dropped.
- R4: Opcode 0 writes rd with ra op rb, selected by the function code: 32 add, 34 subtract, 36 AND, 37 OR, 42 signed set-less-than (result 1 or 0). All results are taken modulo 256.
- R5: Opcode 8 writes rb with ra plus the low byte of the immediate.
- R6: Opcode 4 compares ra and rb. When they are equal, the next fetch starts at (address of the following instruction + immediate×4) mod 256. Otherwise execution goes on at the following instruction.
- R7: Opcode 2 continues at the destination field × 4, truncated to 8 bits.
- R8: Opcode 32 loads the byte at address ra + immediate low byte into rb.
- R9: Opcode 40 writes rb to address ra + immediate low byte during exactly one cycle. The next instruction fetch starts in the following cycle.
- R10: The read and write strobes are never high in the same cycle.
- R11: Any other opcode leaves registers and memory unchanged, and execution continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 8 | Byte address for read or write |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |

## Verification
A corrupted program counter or fetch state shows on the address port within one cycle, because the next fetch address no longer follows the previous one. A wrong instruction byte order, ALU selection or register write stays hidden inside the core. It only becomes visible when a later store puts a wrong byte on the write port, or when a branch or jump sends fetches to the wrong address. For that reason, directed and random programs end by storing every register to memory, and the whole memory image is compared with an independent instruction-level model.

// File: rtl/mcpu8_pkg.sv
package mcpu8_pkg;
  parameter int unsigned XW     = 8;
  parameter int unsigned INSN_W = 32;

  typedef logic [XW-1:0] word_t;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3, S_DEC, S_REX, S_IEX, S_ALUWB,
    S_BEQ, S_JMP, S_MADR, S_MRD, S_MWR, S_LDWB
  } state_t;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} aluop_t;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LB    = 6'd32;
  localparam logic [5:0] OP_SB    = 6'd40;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  function automatic word_t alu_eval(aluop_t op, word_t a, word_t b);
    word_t y;
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? word_t'(1) : word_t'(0);
      default: y = a + b;
    endcase
    return y;
  endfunction
endpackage

// File: rtl/mcpu8_ctrl.sv
module mcpu8_ctrl
  import mcpu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] op,
  output state_t     st
);
  state_t nx;

  always_comb begin
    nx = S_F0;
    case (st)
      S_F0:    nx = S_F1;
      S_F1:    nx = S_F2;
      S_F2:    nx = S_F3;
      S_F3:    nx = S_DEC;
      S_DEC: begin
        case (op)
          OP_RTYPE:     nx = S_REX;
          OP_ADDI:      nx = S_IEX;
          OP_BEQ:       nx = S_BEQ;
          OP_J:         nx = S_JMP;
          OP_LB, OP_SB: nx = S_MADR;
          default:      nx = S_F0;
        endcase
      end
      S_REX, S_IEX: nx = S_ALUWB;
      S_MADR:  nx = (op == OP_LB) ? S_MRD : S_MWR;
      S_MRD:   nx = S_LDWB;
      default: nx = S_F0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_F0;
    else     st <= nx;
  end
endmodule

// File: rtl/mcpu8_aludec.sv
module mcpu8_aludec
  import mcpu8_pkg::*;
(
  input  logic       use_funct,
  input  logic       compare,
  input  logic [5:0] funct,
  output aluop_t     aluop
);
  always_comb begin
    aluop = ALU_ADD;
    if (compare) begin
      aluop = ALU_SUB;
    end else if (use_funct) begin
      case (funct)
        FN_SUB:  aluop = ALU_SUB;
        FN_AND:  aluop = ALU_AND;
        FN_OR:   aluop = ALU_OR;
        FN_SLT:  aluop = ALU_SLT;
        default: aluop = ALU_ADD;
      endcase
    end
  end
endmodule

// File: rtl/mcpu8_regfile.sv
module mcpu8_regfile
  import mcpu8_pkg::*;
#(
  parameter int unsigned NREG = 8,
  localparam int unsigned RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RIW-1:0] ra,
  input  logic [RIW-1:0] rb,
  input  logic           we,
  input  logic [RIW-1:0] wa,
  input  word_t          wd,
  output word_t          qa,
  output word_t          qb
);
  word_t regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      word_t q;
      always_ff @(posedge clk) begin
        if (rst)                           q <= '0;
        else if (we && wa == RIW'(g))      q <= wd;
      end
      assign regs[g] = q;
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];
endmodule

// File: rtl/mcpu8.sv
module mcpu8
  import mcpu8_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [XW-1:0] mem_addr,
  output logic [XW-1:0] mem_wdata,
  input  logic [XW-1:0] mem_rdata
);
  localparam int unsigned RIW    = $clog2(NREG);
  localparam int unsigned IBYTES = INSN_W / XW;

  state_t            st;
  word_t             pc_q, a_q, b_q, res_q, mdr_q;
  logic [INSN_W-1:0] ir_q;

  // instruction fields
  logic [5:0]     op;
  logic [5:0]     funct;
  logic [RIW-1:0] ra_idx, rb_idx, rd_idx;
  word_t          imm8, jmp_dest, br_off;
  assign op       = ir_q[31:26];
  assign funct    = ir_q[5:0];
  assign ra_idx   = ir_q[21 +: RIW];
  assign rb_idx   = ir_q[16 +: RIW];
  assign rd_idx   = ir_q[11 +: RIW];
  assign imm8     = ir_q[XW-1:0];
  assign br_off   = {ir_q[XW-3:0], 2'b00};
  assign jmp_dest = {ir_q[XW-3:0], 2'b00};

  logic unused_fields;
  assign unused_fields = ^{ir_q[25:21+RIW], ir_q[20:16+RIW], ir_q[15:11+RIW], ir_q[10:XW]};

  // named events for the checker
  logic       fetching, fetch_last, jmp_fire, br_fire, mem_phase;
  logic [1:0] fetch_idx;
  assign fetching   = (st < S_DEC);
  assign fetch_last = (st == S_F3);
  assign fetch_idx  = st[1:0];
  assign jmp_fire   = (st == S_JMP);
  assign mem_phase  = (st == S_MRD) || (st == S_MWR);

  mcpu8_ctrl u_ctrl (
    .clk (clk),
    .rst (rst),
    .op  (op),
    .st  (st)
  );

  // register file
  logic           rf_we;
  logic [RIW-1:0] rf_wa;
  word_t          rf_wd, rf_qa, rf_qb;
  assign rf_we = (st == S_ALUWB) || (st == S_LDWB);
  assign rf_wa = (st == S_ALUWB && op == OP_RTYPE) ? rd_idx : rb_idx;
  assign rf_wd = (st == S_LDWB) ? mdr_q : res_q;

  mcpu8_regfile #(.NREG(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra  (ra_idx),
    .rb  (rb_idx),
    .we  (rf_we),
    .wa  (rf_wa),
    .wd  (rf_wd),
    .qa  (rf_qa),
    .qb  (rf_qb)
  );

  // shared ALU
  aluop_t alu_op;
  word_t  alu_a, alu_b, alu_y;
  logic   alu_zero;

  mcpu8_aludec u_dec (
    .use_funct (st == S_REX),
    .compare   (st == S_BEQ),
    .funct     (funct),
    .aluop     (alu_op)
  );

  always_comb begin
    alu_a = a_q;
    alu_b = b_q;
    if (fetching) begin
      alu_a = pc_q;
      alu_b = word_t'(1);
    end else if (st == S_DEC) begin
      alu_a = pc_q;
      alu_b = br_off;
    end else if (st == S_IEX || st == S_MADR) begin
      alu_b = imm8;
    end
  end

  assign alu_y    = alu_eval(alu_op, alu_a, alu_b);
  assign alu_zero = (alu_y == '0);
  assign br_fire  = (st == S_BEQ) && alu_zero;

  // datapath registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      mdr_q <= '0;
    end else begin
      if (fetching) begin
        ir_q[(IBYTES-1-int'(fetch_idx))*XW +: XW] <= mem_rdata;
        pc_q <= alu_y;
      end else if (br_fire) begin
        pc_q <= res_q;
      end else if (jmp_fire) begin
        pc_q <= jmp_dest;
      end
      if (st == S_DEC) begin
        a_q <= rf_qa;
        b_q <= rf_qb;
      end
      if (st == S_DEC || st == S_REX || st == S_IEX || st == S_MADR) res_q <= alu_y;
      if (st == S_MRD) mdr_q <= mem_rdata;
    end
  end

  assign mem_rd    = fetching || (st == S_MRD);
  assign mem_wr    = (st == S_MWR);
  assign mem_addr  = mem_phase ? res_q : pc_q;
  assign mem_wdata = b_q;
endmodule

// File: rtl/mcpu8_chk.sv
module mcpu8_chk
  import mcpu8_pkg::*;
#(
  parameter int unsigned NREG = 8,
  localparam int unsigned RIW = $clog2(NREG)
) (
  input logic           clk,
  input logic           rst,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [XW-1:0]  mem_addr,
  input logic           fetching,
  input logic           fetch_last,
  input logic [RIW-1:0] rf_ra,
  input logic [XW-1:0]  rf_qa,
  input logic           jmp_fire,
  input logic [XW-1:0]  jmp_dest
);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_rd && !mem_wr && mem_addr == '0));

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    (fetching && !fetch_last) |=> (fetching && mem_rd && mem_addr == $past(mem_addr) + 1'b1));

  assert_decode_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_last |=> (!mem_rd && !mem_wr));

  assert_zero_reg_R3: assert property (@(posedge clk) disable iff (rst)
    (rf_ra == '0) |-> (rf_qa == '0));

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    jmp_fire |=> (fetching && mem_addr == $past(jmp_dest)));

  assert_store_single_R9: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (!mem_wr && fetching));
endmodule

bind mcpu8 mcpu8_chk #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .fetching   (fetching),
  .fetch_last (fetch_last),
  .rf_ra      (ra_idx),
  .rf_qa      (rf_qa),
  .jmp_fire   (jmp_fire),
  .jmp_dest   (jmp_dest)
);

// File: tb/mcpu8_bench.sv
`timescale 1ns/1ps
module mcpu8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic       mem_rd, mem_wr;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] dmem [256];
  logic [7:0] img  [256];
  logic [7:0] refm [256];
  int errors = 0;
  int checks = 0;
  int both_cnt = 0;
  int pa = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mcpu8 u_mcpu8 (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = dmem[mem_addr];

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 256; i++) dmem[i] <= img[i];
    end else if (mem_wr) begin
      dmem[mem_addr] <= mem_wdata;
    end
  end

  always @(negedge clk) if (!rst && mem_rd && mem_wr) both_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int ra, int rb, int rd, logic [5:0] fn);
    return {6'd0, 5'(ra), 5'(rb), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int ra, int rb, logic [15:0] imm);
    return {op, 5'(ra), 5'(rb), imm};
  endfunction
  function automatic logic [31:0] enc_j(int dest);
    return {6'd2, 26'(dest)};
  endfunction

  task automatic put(input logic [31:0] w);
    for (int k = 0; k < 4; k++) img[(pa + k) & 255] = w[31 - 8*k -: 8];
    pa += 4;
  endtask

  function automatic logic [7:0] ref_alu(logic [5:0] fn, logic [7:0] a, logic [7:0] b);
    case (fn)
      6'd34:   return a + ~b + 8'd1;
      6'd36:   return ~(~a | ~b);
      6'd37:   return ~(~a & ~b);
      6'd42:   return ((a[7] && !b[7]) || (a[7] == b[7] && a < b)) ? 8'd1 : 8'd0;
      default: return a + b;
    endcase
  endfunction

  // instruction-level model; returns expected cycle count to the halt jump
  task automatic run_model(output int cyc);
    logic [7:0]  r [8];
    logic [7:0]  pc, npc, a, b, imm, tgt;
    logic [31:0] w;
    for (int i = 0; i < 256; i++) refm[i] = img[i];
    for (int i = 0; i < 8; i++) r[i] = 8'd0;
    pc = 8'd0;
    cyc = 0;
    for (int step = 0; step < 4000; step++) begin
      w   = {refm[pc], refm[8'(pc + 1)], refm[8'(pc + 2)], refm[8'(pc + 3)]};
      npc = pc + 8'd4;
      a   = r[w[23:21]];
      b   = r[w[18:16]];
      imm = w[7:0];
      cyc += 5;
      if (w[31:26] == 6'd2) begin
        cyc += 1;
        tgt = {w[5:0], 2'b00};
        if (tgt == pc) break;
        pc = tgt;
      end else begin
        case (w[31:26])
          6'd0:  begin cyc += 2; if (w[13:11] != 0) r[w[13:11]] = ref_alu(w[5:0], a, b); end
          6'd8:  begin cyc += 2; if (w[18:16] != 0) r[w[18:16]] = a + imm; end
          6'd4:  begin cyc += 1; if (a == b) npc = npc + {imm[5:0], 2'b00}; end
          6'd32: begin cyc += 3; if (w[18:16] != 0) r[w[18:16]] = refm[8'(a + imm)]; end
          6'd40: begin cyc += 2; refm[8'(a + imm)] = b; end
          default: ;
        endcase
        pc = npc;
      end
    end
  endtask

  task automatic run_dut(input int cyc, input bit reset_checks);
    @(negedge clk);
    rst = 1'b1; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check(!mem_wr, "R1", mem_wr, 0, "write strobe during reset");
    @(negedge clk);
    rst = 1'b0;
    if (reset_checks) begin
      check(mem_rd && !mem_wr && mem_addr == 8'd0, "R1", {mem_rd, mem_wr, mem_addr}, 10'h200, "first access after reset");
      for (int k = 1; k < 4; k++) begin
        @(negedge clk);
        check(mem_rd && mem_addr == 8'(k), "R2", mem_addr, k, "fetch byte address");
      end
      @(negedge clk);
      check(!mem_rd && !mem_wr, "R2", {mem_rd, mem_wr}, 0, "decode cycle strobes");
    end
    repeat (cyc + 30) @(negedge clk);
  endtask

  task automatic slot(input int addr, input string tag);
    check(dmem[addr] === refm[addr], tag, dmem[addr], refm[addr], $sformatf("result byte at %0h", addr));
  endtask

  task automatic build_directed();
    int loop_at;
    for (int i = 0; i < 256; i++) img[i] = 8'd0;
    pa = 0;
    img[8'hE0] = 8'hA7;
    put(enc_i(8, 0, 1, 16'd5));
    put(enc_i(8, 0, 2, 16'hFFFD));
    put(enc_r(1, 2, 3, 6'd32)); put(enc_i(40, 0, 3, 16'hC0));
    put(enc_r(1, 2, 3, 6'd34)); put(enc_i(40, 0, 3, 16'hC1));
    put(enc_r(1, 2, 3, 6'd36)); put(enc_i(40, 0, 3, 16'hC2));
    put(enc_r(1, 2, 3, 6'd37)); put(enc_i(40, 0, 3, 16'hC3));
    put(enc_r(1, 2, 3, 6'd42)); put(enc_i(40, 0, 3, 16'hC4));
    put(enc_r(2, 1, 3, 6'd42)); put(enc_i(40, 0, 3, 16'hC5));
    put(enc_i(8, 0, 0, 16'd9));  put(enc_i(40, 0, 0, 16'hC6));
    put(enc_i(8, 1, 6, 16'h1234)); put(enc_i(40, 0, 6, 16'hC7));
    put(enc_i(4, 1, 1, 16'd1)); put(enc_i(8, 0, 4, 16'h11)); put(enc_i(40, 0, 4, 16'hC8));
    put(enc_i(4, 1, 2, 16'd1)); put(enc_i(8, 0, 4, 16'h22)); put(enc_i(40, 0, 4, 16'hC9));
    put(enc_j((pa + 8) >> 2)); put(enc_i(8, 0, 4, 16'h33)); put(enc_i(40, 0, 4, 16'hCA));
    put(enc_i(8, 0, 7, 16'h40)); put(enc_i(32, 7, 5, 16'hA0)); put(enc_i(40, 0, 5, 16'hCB));
    put(enc_i(40, 7, 5, 16'hA1));
    put({6'd63, 26'd0}); put(enc_i(8, 0, 4, 16'h44)); put(enc_i(40, 0, 4, 16'hCC));
    put(enc_i(8, 0, 1, 16'd1)); put(enc_i(8, 0, 2, 16'd1));
    put(enc_i(8, 0, 3, 16'd5)); put(enc_i(8, 0, 7, 16'hD0));
    loop_at = pa;
    put(enc_i(40, 7, 1, 16'd0));
    put(enc_r(1, 2, 4, 6'd32)); put(enc_r(2, 0, 1, 6'd32)); put(enc_r(4, 0, 2, 6'd32));
    put(enc_i(8, 7, 7, 16'd1)); put(enc_i(8, 3, 3, 16'hFFFF));
    put(enc_i(4, 3, 0, 16'd1)); put(enc_j(loop_at >> 2));
    put(enc_j(pa >> 2));
  endtask

  task automatic build_random(input int n);
    logic [5:0] fns [5];
    fns = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42};
    for (int i = 0; i < 256; i++) img[i] = (i >= 8'hC0) ? 8'($urandom) : 8'd0;
    pa = 0;
    for (int i = 0; i < n; i++) begin
      case ($urandom % 5)
        0: put(enc_r($urandom % 8, $urandom % 8, $urandom % 8, fns[$urandom % 5]));
        1: put(enc_i(8, $urandom % 8, $urandom % 8, 16'($urandom)));
        2: put(enc_i(40, 0, $urandom % 8, 16'(8'hC0 + $urandom % 32)));
        3: put(enc_i(32, 0, $urandom % 8, 16'(8'hC0 + $urandom % 32)));
        default: put(enc_i(4, $urandom % 8, $urandom % 8, 16'd1));
      endcase
    end
    for (int i = 1; i < 8; i++) put(enc_i(40, 0, i, 16'(8'hF0 + i)));
    put(enc_j(pa >> 2));
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) dmem[i] = 8'd0;

    build_directed();
    run_model(cyc);
    run_dut(cyc, 1'b1);
    for (int i = 0; i < 6; i++) slot(8'hC0 + i, "R4");
    slot(8'hC6, "R3");
    slot(8'hC7, "R5");
    slot(8'hC8, "R6");
    slot(8'hC9, "R6");
    slot(8'hCA, "R7");
    slot(8'hCB, "R8");
    slot(8'hE1, "R9");
    slot(8'hCC, "R11");
    for (int i = 0; i < 5; i++) slot(8'hD0 + i, "R6");
    for (int i = 0; i < 256; i++) slot(i, "R2");

    for (int t = 0; t < 10; t++) begin
      build_random(20 + t % 5);
      run_model(cyc);
      run_dut(cyc, 1'b0);
      for (int i = 0; i < 256; i++) slot(i, (i > 8'hF0 && i < 8'hF8) ? "R1" : "R4");
    end

    check(both_cnt == 0, "R10", both_cnt, 0, "cycles with both strobes");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule